// File: doc/BRIEF.md
# Acquisition Group Transfer Counter and Interrupt Flag Unit

This block keeps the status of one data-acquisition group. Before a run, software loads a 32-bit transfer counter with the number of samples it wants. Each sample that the sampling engine accepts takes one off the count. When the last sample is taken, the block latches a count-expired event.

Overrun and the two terminal-count events come in on their own inputs and are held in a byte-wide flag register. The transfer-ready bit of that register follows its input live. An enable byte with the same bit layout masks the flags. A master control byte selects the interrupt line and the open-drain drive, and it gates the interrupt output.

Latched flags are cleared through two write-only clear registers. Their bit positions are not those of the flags. The first clear register can also request one-cycle reset pulses for the DMA logic and for the FIFO. A data-left status bit shows that enabled work is still pending.

Register offsets on `regAddr`: 0 counter (write loads, read gives the live count), 1 flags (read), 2 interrupt enable (read/write), 3 first clear (write), 4 second clear (write), 5 master control (read/write), 6 status (read). Register writes and event inputs take effect at the rising clock edge. Reads are combinational on `regAddr`.

Top module: `xfer_status_unit`

## Requirements
- R1: After reset, the counter reads 0, the flags read 0 with the ready input low, the enable and master bytes read 0, and `irqOut`, `dmaResetPulse` and `fifoResetPulse` are low.
- R2: A write to offset 0 loads the counter with `regWrData`. If a sample is accepted in the same cycle, the load wins and the counter reads back the written value.
- R3: Each cycle with `evtSample` high and a nonzero count lowers the count by one. The step from 1 to 0 sets flag bit1 (count expired).
- R4: At count 0, `evtSample` changes neither the counter nor flag bit1. So a counter loaded with 0 never raises count expired.
- R5: In the flags byte, bit0 follows `evtReady` combinationally. Bit5 latches `evtWaited`, bit6 latches `evtPrimaryTc` and bit7 latches `evtSecondaryTc`. Bits 2 to 4 read 0.
- R6: In the first clear register (offset 3), bit3 clears flag bit5, bit4 clears flag bit6 and bit5 clears flag bit7. No bit of this register clears flag bit1. Flag bit1 is cleared only by bit0 of the second clear register (offset 4).
- R7: When a flag's event and its clear bit arrive in the same cycle, the flag is set after that edge.
- R8: A write to offset 3 with bit6 set drives `dmaResetPulse` high for exactly the next cycle. Bit7 does the same for `fifoResetPulse`.
- R9: `irqOut` is high when any flag bit ANDed with the enable byte (offset 2) is set and master bits 1:0 are nonzero. `irqLine` shows master bits 1:0 and `irqOpenDrain` shows master bit2. Writing 0 to the master byte turns the interrupt off.
- R10: Status (offset 6) bit0 is the data-left bit. It is high when any enabled flag bit is set, whatever the master byte holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register offset for both write and read |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for `regAddr` |
| evtSample | input | 1 | Sampling engine accepted one sample |
| evtReady | input | 1 | Transfer-ready level |
| evtWaited | input | 1 | Overrun event |
| evtPrimaryTc | input | 1 | Primary terminal-count event |
| evtSecondaryTc | input | 1 | Secondary terminal-count event |
| irqOut | output | 1 | Interrupt request |
| irqLine | output | 2 | Selected interrupt line |
| irqOpenDrain | output | 1 | Open-drain drive select |
| dataLeft | output | 1 | Enabled work pending |
| dmaResetPulse | output | 1 | One-cycle DMA logic reset |
| fifoResetPulse | output | 1 | One-cycle FIFO reset |

## Verification
Counter, flag, enable and master values change at the rising edge that samples the write or event. From the next cycle they can be read through the combinational read path, and `irqOut` and `dataLeft` follow them in that same cycle. The reset pulses are high only in the one cycle after the clear write. The bench drives inputs just after a rising edge and compares outputs at the following falling edge, so every expected value falls due in the cycle in which it is sampled. A second compare one cycle later confirms that each pulse has gone back low.

// File: rtl/xfer_status_pkg.sv
package xfer_status_pkg;

  // flag register bit positions (enable register shares them)
  localparam int FLG_READY   = 0;
  localparam int FLG_EXPIRED = 1;
  localparam int FLG_WAITED  = 5;
  localparam int FLG_PTC     = 6;
  localparam int FLG_STC     = 7;

  // first clear register
  localparam int CLR1_WAITED = 3;
  localparam int CLR1_PTC    = 4;
  localparam int CLR1_STC    = 5;
  localparam int CLR1_DMA    = 6;
  localparam int CLR1_FIFO   = 7;

  // second clear register
  localparam int CLR2_EXPIRED = 0;

  // master control
  localparam int MC_OPEN_DRAIN = 2;

  // register offsets
  localparam int ADR_COUNT  = 0;
  localparam int ADR_FLAGS  = 1;
  localparam int ADR_INTEN  = 2;
  localparam int ADR_CLR1   = 3;
  localparam int ADR_CLR2   = 4;
  localparam int ADR_MASTER = 5;
  localparam int ADR_STATUS = 6;

  localparam int NUM_LATCHED = 3;

  typedef struct packed {
    logic loadCnt;
    logic clrWaited;
    logic clrPtc;
    logic clrStc;
    logic clrExpired;
  } strobe_t;

endpackage

// File: rtl/xfer_status_ctrl.sv
module xfer_status_ctrl
  import xfer_status_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrByte,
  output strobe_t           strb,
  output logic [7:0]        intEn,
  output logic [7:0]        masterCtl,
  output logic              dmaRst,
  output logic              fifoRst
);

  logic wrCount, wrClr1, wrClr2, wrInten, wrMaster;

  always_comb begin
    wrCount  = wrEn && (addr == ADDR_W'(ADR_COUNT));
    wrClr1   = wrEn && (addr == ADDR_W'(ADR_CLR1));
    wrClr2   = wrEn && (addr == ADDR_W'(ADR_CLR2));
    wrInten  = wrEn && (addr == ADDR_W'(ADR_INTEN));
    wrMaster = wrEn && (addr == ADDR_W'(ADR_MASTER));
  end

  always_comb begin
    strb.loadCnt    = wrCount;
    strb.clrWaited  = wrClr1 && wrByte[CLR1_WAITED];
    strb.clrPtc     = wrClr1 && wrByte[CLR1_PTC];
    strb.clrStc     = wrClr1 && wrByte[CLR1_STC];
    strb.clrExpired = wrClr2 && wrByte[CLR2_EXPIRED];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      intEn     <= '0;
      masterCtl <= '0;
      dmaRst    <= 1'b0;
      fifoRst   <= 1'b0;
    end else begin
      if (wrInten)  intEn     <= wrByte;
      if (wrMaster) masterCtl <= wrByte;
      dmaRst  <= wrClr1 && wrByte[CLR1_DMA];
      fifoRst <= wrClr1 && wrByte[CLR1_FIFO];
    end
  end

endmodule

// File: rtl/xfer_status_dp.sv
module xfer_status_dp
  import xfer_status_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [CNT_W-1:0] loadVal,
  input  logic             evtSample,
  input  logic             evtReady,
  input  logic             evtWaited,
  input  logic             evtPtc,
  input  logic             evtStc,
  output logic [CNT_W-1:0] cnt,
  output logic [7:0]       flags
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic                   expired;
  logic                   expSet;
  logic [NUM_LATCHED-1:0] latched;
  logic [NUM_LATCHED-1:0] evtVec;
  logic [NUM_LATCHED-1:0] clrVec;

  always_comb begin
    expSet = evtSample && !strb.loadCnt && (cnt == ONE);
    evtVec = {evtStc, evtPtc, evtWaited};
    clrVec = {strb.clrStc, strb.clrPtc, strb.clrWaited};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strb.loadCnt) begin
      cnt <= loadVal;
    end else if (evtSample && (cnt != '0)) begin
      cnt <= cnt - ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) expired <= 1'b0;
    else       expired <= expSet | (expired & ~strb.clrExpired);
  end

  for (genvar gi = 0; gi < NUM_LATCHED; gi++) begin : g_latch
    always_ff @(posedge clk) begin
      if (!rstN) latched[gi] <= 1'b0;
      else       latched[gi] <= evtVec[gi] | (latched[gi] & ~clrVec[gi]);
    end
  end

  always_comb begin
    flags              = '0;
    flags[FLG_READY]   = evtReady;
    flags[FLG_EXPIRED] = expired;
    flags[FLG_WAITED]  = latched[0];
    flags[FLG_PTC]     = latched[1];
    flags[FLG_STC]     = latched[2];
  end

endmodule

// File: rtl/xfer_status_unit.sv
module xfer_status_unit
  import xfer_status_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              evtSample,
  input  logic              evtReady,
  input  logic              evtWaited,
  input  logic              evtPrimaryTc,
  input  logic              evtSecondaryTc,
  output logic              irqOut,
  output logic [1:0]        irqLine,
  output logic              irqOpenDrain,
  output logic              dataLeft,
  output logic              dmaResetPulse,
  output logic              fifoResetPulse
);

  strobe_t          strb;
  logic [7:0]       intEnValue;
  logic [7:0]       masterValue;
  logic [7:0]       flagsValue;
  logic [CNT_W-1:0] cntValue;

  xfer_status_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (regWrEn),
    .addr      (regAddr),
    .wrByte    (regWrData[7:0]),
    .strb      (strb),
    .intEn     (intEnValue),
    .masterCtl (masterValue),
    .dmaRst    (dmaResetPulse),
    .fifoRst   (fifoResetPulse)
  );

  xfer_status_dp #(.CNT_W(CNT_W)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .loadVal   (regWrData[CNT_W-1:0]),
    .evtSample (evtSample),
    .evtReady  (evtReady),
    .evtWaited (evtWaited),
    .evtPtc    (evtPrimaryTc),
    .evtStc    (evtSecondaryTc),
    .cnt       (cntValue),
    .flags     (flagsValue)
  );

  always_comb begin
    dataLeft     = |(flagsValue & intEnValue);
    irqLine      = masterValue[1:0];
    irqOpenDrain = masterValue[MC_OPEN_DRAIN];
    irqOut       = dataLeft && (masterValue[1:0] != 2'b00);
  end

  always_comb begin
    case (regAddr)
      ADDR_W'(ADR_COUNT):  regRdData = DATA_W'(cntValue);
      ADDR_W'(ADR_FLAGS):  regRdData = DATA_W'(flagsValue);
      ADDR_W'(ADR_INTEN):  regRdData = DATA_W'(intEnValue);
      ADDR_W'(ADR_MASTER): regRdData = DATA_W'(masterValue);
      ADDR_W'(ADR_STATUS): regRdData = DATA_W'(dataLeft);
      default:             regRdData = '0;
    endcase
  end

endmodule

// File: rtl/xfer_status_chk.sv
module xfer_status_chk
  import xfer_status_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regWrData,
  input logic              evtSample,
  input logic              evtWaited,
  input logic [CNT_W-1:0]  cntValue,
  input logic [7:0]        flagsValue,
  input logic              irqOut,
  input logic              dmaResetPulse
);

  logic loadNow;
  always_comb loadNow = regWrEn && (regAddr == ADDR_W'(ADR_COUNT));

  a_r2_load_value: assert property (@(posedge clk) disable iff (!rstN)
    loadNow |=> cntValue == $past(regWrData[CNT_W-1:0]));

  a_r3_expire_on_last: assert property (@(posedge clk) disable iff (!rstN)
    (evtSample && !loadNow && cntValue == CNT_W'(1)) |=> flagsValue[FLG_EXPIRED]);

  a_r4_hold_at_zero: assert property (@(posedge clk) disable iff (!rstN)
    (cntValue == '0 && !loadNow) |=> cntValue == '0);

  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    evtWaited |=> flagsValue[FLG_WAITED]);

  a_r8_dma_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_W'(ADR_CLR1) && regWrData[CLR1_DMA]) |=> dmaResetPulse);

  a_r9_master_off: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_W'(ADR_MASTER) && regWrData[7:0] == 8'h00) |=> !irqOut);

endmodule

bind xfer_status_unit xfer_status_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
) i_chk (
  .clk          (clk),
  .rstN         (rstN),
  .regWrEn      (regWrEn),
  .regAddr      (regAddr),
  .regWrData    (regWrData),
  .evtSample    (evtSample),
  .evtWaited    (evtWaited),
  .cntValue     (cntValue),
  .flagsValue   (flagsValue),
  .irqOut       (irqOut),
  .dmaResetPulse(dmaResetPulse)
);

// File: tb/test_xfer_status_unit.sv
module test_xfer_status_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        evtSample = 1'b0, evtReady = 1'b0, evtWaited = 1'b0;
  logic        evtPrimaryTc = 1'b0, evtSecondaryTc = 1'b0;
  logic        irqOut, irqOpenDrain, dataLeft, dmaResetPulse, fifoResetPulse;
  logic [1:0]  irqLine;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  xfer_status_unit i_xfer_status_unit (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .evtSample(evtSample),
    .evtReady(evtReady), .evtWaited(evtWaited), .evtPrimaryTc(evtPrimaryTc),
    .evtSecondaryTc(evtSecondaryTc), .irqOut(irqOut), .irqLine(irqLine),
    .irqOpenDrain(irqOpenDrain), .dataLeft(dataLeft),
    .dmaResetPulse(dmaResetPulse), .fifoResetPulse(fifoResetPulse)
  );

  // sel: 0 read data, 1 irqOut, 2 dma pulse, 3 fifo pulse, 4 irqLine, 5 open drain, 6 dataLeft
  typedef struct {
    int          sel;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  item_t cur;
  logic [31:0] act;

  always @(negedge clk) begin
    if (q.size() > 0) begin
      cur = q.pop_front();
      case (cur.sel)
        0: act = regRdData;
        1: act = 32'(irqOut);
        2: act = 32'(dmaResetPulse);
        3: act = 32'(fifoResetPulse);
        4: act = 32'(irqLine);
        5: act = 32'(irqOpenDrain);
        default: act = 32'(dataLeft);
      endcase
      checks++;
      if (act !== cur.exp) begin
        failures++;
        $display("FAIL %s: actual=%h expected=%h", cur.tag, act, cur.exp);
      end
    end
  end

  task automatic expectOut(int sel, logic [2:0] a, logic [31:0] e, string tag);
    item_t it;
    if (sel == 0) regAddr = a;
    it.sel = sel; it.exp = e; it.tag = tag;
    q.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic stepIn(bit smp, bit wt, bit pt, bit st, bit wr, logic [2:0] a,
                        logic [31:0] d);
    @(posedge clk); #1;
    evtSample = smp; evtWaited = wt; evtPrimaryTc = pt; evtSecondaryTc = st;
    regWrEn = wr; regAddr = a; regWrData = d;
    @(posedge clk); #1;
    evtSample = 0; evtWaited = 0; evtPrimaryTc = 0; evtSecondaryTc = 0;
    regWrEn = 0;
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    stepIn(0, 0, 0, 0, 1, a, d);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1 reset state
    expectOut(0, 0, 0, "R1 counter");
    expectOut(0, 1, 0, "R1 flags");
    expectOut(0, 2, 0, "R1 enable");
    expectOut(0, 5, 0, "R1 master");
    expectOut(1, 0, 0, "R1 irq");
    expectOut(2, 0, 0, "R1 dma pulse");
    expectOut(3, 0, 0, "R1 fifo pulse");
    // R2 load
    wr(0, 32'h0000_0003);
    expectOut(0, 0, 3, "R2 load readback");
    // R3 decrement and expiry
    stepIn(1, 0, 0, 0, 0, 0, 0);
    stepIn(1, 0, 0, 0, 0, 0, 0);
    expectOut(0, 0, 1, "R3 count after two samples");
    expectOut(0, 1, 0, "R3 no expiry yet");
    stepIn(1, 0, 0, 0, 0, 0, 0);
    expectOut(0, 0, 0, "R3 count reached zero");
    expectOut(0, 1, 32'h02, "R3 expired set");
    // R4 hold at zero
    stepIn(1, 0, 0, 0, 0, 0, 0);
    expectOut(0, 0, 0, "R4 no decrement at zero");
    // R6 first clear cannot clear expired
    wr(3, 32'h0000_003A);
    expectOut(0, 1, 32'h02, "R6 first clear leaves expired");
    wr(4, 32'h0000_0001);
    expectOut(0, 1, 0, "R6 second clear bit0 clears expired");
    // R4 load zero never expires
    wr(0, 0);
    stepIn(1, 0, 0, 0, 0, 0, 0);
    expectOut(0, 1, 0, "R4 zero load no expiry");
    expectOut(0, 0, 0, "R4 zero load counter");
    // R2 load beats sample
    stepIn(1, 0, 0, 0, 1, 0, 32'hDEAD_0005);
    expectOut(0, 0, 32'hDEAD_0005, "R2 load wins over sample");
    stepIn(1, 0, 0, 0, 0, 0, 0);
    expectOut(0, 0, 32'hDEAD_0004, "R3 large count decrement");
    wr(0, 0);
    // R5 events and ready
    stepIn(0, 1, 1, 1, 0, 0, 0);
    expectOut(0, 1, 32'hE0, "R5 latched events");
    evtReady = 1;
    expectOut(0, 1, 32'hE1, "R5 ready live high");
    evtReady = 0;
    expectOut(0, 1, 32'hE0, "R5 ready live low");
    // R6 individual clears
    wr(3, 32'h08);
    expectOut(0, 1, 32'hC0, "R6 clear waited");
    wr(3, 32'h10);
    expectOut(0, 1, 32'h80, "R6 clear primary tc");
    wr(3, 32'h20);
    expectOut(0, 1, 32'h00, "R6 clear secondary tc");
    // R7 set wins over clear
    stepIn(0, 1, 0, 0, 1, 3, 32'h08);
    expectOut(0, 1, 32'h20, "R7 waited set wins");
    wr(0, 1);
    stepIn(1, 0, 0, 0, 1, 4, 32'h01);
    expectOut(0, 1, 32'h22, "R7 expired set wins");
    wr(3, 32'h08);
    wr(4, 32'h01);
    expectOut(0, 1, 0, "R6 all cleared");
    // R8 reset pulses
    wr(3, 32'h40);
    expectOut(2, 0, 1, "R8 dma pulse high");
    expectOut(2, 0, 0, "R8 dma pulse one cycle");
    expectOut(3, 0, 0, "R8 fifo quiet on dma");
    wr(3, 32'h80);
    expectOut(3, 0, 1, "R8 fifo pulse high");
    expectOut(3, 0, 0, "R8 fifo pulse one cycle");
    // R9 R10 interrupt
    wr(2, 32'h20);
    expectOut(0, 2, 32'h20, "R9 enable readback");
    stepIn(0, 0, 1, 0, 0, 0, 0);
    expectOut(6, 0, 0, "R10 masked flag not data left");
    expectOut(1, 0, 0, "R9 masked flag no irq");
    stepIn(0, 1, 0, 0, 0, 0, 0);
    expectOut(6, 0, 1, "R10 data left");
    expectOut(0, 6, 1, "R10 status bit0");
    expectOut(1, 0, 0, "R9 line zero no irq");
    wr(5, 32'h01);
    expectOut(1, 0, 1, "R9 irq asserted");
    expectOut(4, 0, 1, "R9 line select");
    wr(5, 32'h04);
    expectOut(1, 0, 0, "R9 line zero open drain no irq");
    expectOut(5, 0, 1, "R9 open drain");
    expectOut(0, 6, 1, "R10 status independent of master");
    wr(5, 32'h03);
    expectOut(1, 0, 1, "R9 irq line 3");
    wr(5, 32'h00);
    expectOut(1, 0, 0, "R9 zero master disables");
    expectOut(5, 0, 0, "R9 open drain off");
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule